// File: doc/BRIEF.md
# Transmit Descriptor Ring Controller

This block walks a circular ring of 64-bit transmit descriptors for a single DMA channel. Software posts work by writing a kick: a tail entry index plus a lap flag that software toggles each time its tail index wraps back to entry 0. The controller holds a head index with its own lap flag. It fetches the descriptor at the head through a simple request/response memory port, at address `ring_base + 8*head`. It decodes the descriptor and hands a transfer request (start-of-frame, length, buffer address) to a downstream packet reader with a valid/ready handshake. The head then moves on by one entry.

The ring holds work while the head and tail indices differ or the two lap flags differ. Equal indices with differing lap flags mean a completely full ring. The engine leaves reset parked in a stalled state and fetches nothing until software releases it. A control reset request brings the head back to 0 and parks the engine again. The tail is never changed by the hardware, so after a release the head runs up to whatever tail software left behind. A stop request lets the engine finish the descriptor in hand and then park in a stopped state. A sticky flag records that a marked descriptor has completed, and a status read clears it.

Top module: `txq_ring_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, head_idx is 0, head_wrap is 0, rst_state is 1, sng_state, mk_flag, desc_err and ovf_err are 0, and neither mem_req nor xfer_valid is asserted.
- R2: While rst_state is 1 no descriptor is fetched, even if a kick has posted work. A one-cycle ctl_stall_clr pulse releases the engine, which then starts at the current head.
- R3: A fetch starts only when the ring holds work: head_idx differs from the tail, or head_wrap differs from the tail lap flag. Equal indices with differing lap flags cause all RING_LEN entries to be processed.
- R4: Each fetch is a one-cycle mem_req pulse with mem_addr = ring_base + 8*head_idx. Only one fetch is outstanding, and the next one is issued only after the previous descriptor has been accepted or skipped.
- R5: Descriptor bit 63 drives xfer_sof, bits 56..44 drive xfer_len and bits 43..0 drive xfer_addr. A transfer request is held stable with xfer_valid high until xfer_ready is seen.
- R6: head_idx advances by exactly one after a transfer request is accepted or a bad descriptor is skipped. Advancing from RING_LEN-1 wraps to 0 and toggles head_wrap.
- R7: A descriptor whose length (bits 56..44) is 0 or whose gather count (bits 61..58) is not 1 produces no transfer request. It is skipped, and desc_err is set and stays set until a control reset.
- R8: A kick is rejected when it would put the tail more than one ring ahead of the head: index below the head with equal lap flags, or above the head with differing flags, or an index not below RING_LEN. A rejected kick leaves the tail unchanged and sets ovf_err, which stays set until a control reset.
- R9: When a transfer request from a descriptor with bit 62 (mark) set is accepted, mk_flag is set. A stat_rd pulse clears it, and a same-cycle completion wins over the clear.
- R10: After ctl_stop_req the engine completes the descriptor in hand. It then raises sng_state and issues no fetch until a control reset.
- R11: ctl_rst_req raises rst_busy until the reset completes. The reset then sets head_idx and head_wrap to 0, clears desc_err and ovf_err, sets rst_state and keeps the tail, so after release the head follows the old tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | AW | Byte address of ring entry 0 |
| kick_wr | input | 1 | Kick write strobe |
| kick_idx | input | IDX_W | New tail entry index |
| kick_wrap | input | 1 | New tail lap flag |
| ctl_rst_req | input | 1 | Control reset request pulse |
| ctl_stall_clr | input | 1 | Release pulse out of the stalled state |
| ctl_stop_req | input | 1 | Stop request pulse |
| stat_rd | input | 1 | Status read pulse, clears mk_flag |
| mem_req | output | 1 | Descriptor fetch request pulse |
| mem_addr | output | AW | Descriptor fetch address |
| mem_rsp_valid | input | 1 | Fetch response valid |
| mem_rsp_data | input | 64 | Fetched descriptor word |
| xfer_valid | output | 1 | Transfer request valid |
| xfer_ready | input | 1 | Downstream reader accepts the request |
| xfer_sof | output | 1 | Start-of-frame flag of the request |
| xfer_len | output | 13 | Transfer length in bytes |
| xfer_addr | output | 44 | Buffer address |
| head_idx | output | IDX_W | Current head entry index |
| head_wrap | output | 1 | Head lap flag |
| mk_flag | output | 1 | Sticky marked-descriptor-done flag |
| desc_err | output | 1 | Sticky bad-descriptor flag |
| ovf_err | output | 1 | Sticky kick-overflow flag |
| rst_busy | output | 1 | Control reset in progress |
| rst_state | output | 1 | Engine parked after reset |
| sng_state | output | 1 | Engine stopped after a stop request |

## Verification
A head pointer that steps wrongly shows on mem_addr at the very next fetch, within about three cycles of an acceptance. A lap flag that is lost or flipped shows as a ring that runs dry early or keeps running past the tail, so the count of fetches after a wrapping kick tells it apart. A decoder that takes fields from the wrong bits shows on the transfer request in the cycle the descriptor returns. A reset or stop sequence stuck in the wrong state shows as rst_state, sng_state or rst_busy holding the wrong value a few cycles after the request, or as fetches that should not happen.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int DESC_W = 64;
  localparam int XLEN_W = 13;
  localparam int BUFA_W = 44;
  localparam int GCNT_W = 4;

  // Field layout of one ring entry; the downstream reader relies on it.
  typedef struct packed {
    logic              sof;
    logic              mark;
    logic [GCNT_W-1:0] gcnt;
    logic              rsvd;
    logic [XLEN_W-1:0] xlen;
    logic [BUFA_W-1:0] bufa;
  } txq_desc_t;

  typedef enum logic [2:0] {
    ST_STALL,
    ST_IDLE,
    ST_FETCH,
    ST_OFFER,
    ST_STOPPED,
    ST_RESET
  } txq_state_e;
endpackage

// File: rtl/txq_desc_check.sv
module txq_desc_check
  import txq_pkg::*;
(
  input  logic [DESC_W-1:0] word,
  output logic              sof,
  output logic              mark,
  output logic [XLEN_W-1:0] xlen,
  output logic [BUFA_W-1:0] bufa,
  output logic              bad
);
  txq_desc_t d;
  logic      unused_rsvd;

  assign d           = txq_desc_t'(word);
  assign sof         = d.sof;
  assign mark        = d.mark;
  assign xlen        = d.xlen;
  assign bufa        = d.bufa;
  assign unused_rsvd = d.rsvd;
  // R7: zero length or a pointer count other than one is unusable
  assign bad = (d.xlen == '0) || (d.gcnt != GCNT_W'(1));
endmodule

// File: rtl/txq_kick_track.sv
module txq_kick_track #(
  parameter  int RING_LEN = 64,
  localparam int IDX_W    = $clog2(RING_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kick_wr,
  input  logic [IDX_W-1:0] kick_idx,
  input  logic             kick_wrap,
  input  logic [IDX_W-1:0] head_idx,
  input  logic             head_wrap,
  input  logic             ovf_clr,
  output logic             ring_empty,
  output logic             ovf_err
);
  logic [IDX_W-1:0] tail_q;
  logic             twrap_q;
  logic             ovf_q;
  logic             idx_in_range;
  logic             same_lap;
  logic             kick_ok;

  generate
    if ((RING_LEN & (RING_LEN - 1)) == 0) begin : g_pow2
      assign idx_in_range = 1'b1;
    end else begin : g_npow2
      assign idx_in_range = (kick_idx < IDX_W'(RING_LEN));
    end
  endgenerate

  // R8: tail may be at most one full ring ahead of the head
  assign same_lap = (kick_wrap == head_wrap);
  assign kick_ok  = idx_in_range &&
                    (same_lap ? (kick_idx >= head_idx) : (kick_idx <= head_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      tail_q  <= '0;
      twrap_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (ovf_clr) ovf_q <= 1'b0;
      if (kick_wr) begin
        if (kick_ok) begin
          tail_q  <= kick_idx;
          twrap_q <= kick_wrap;
        end else begin
          ovf_q <= 1'b1;
        end
      end
    end
  end

  // R3: empty only when both index and lap flag match
  assign ring_empty = (tail_q == head_idx) && (twrap_q == head_wrap);
  assign ovf_err    = ovf_q;

  a_r8_reject_keeps_tail: assert property (@(posedge clk) disable iff (rst)
    kick_wr && !kick_ok |=> (tail_q == $past(tail_q)) && (twrap_q == $past(twrap_q)));

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_q && !ovf_clr |=> ovf_q);
endmodule

// File: rtl/txq_head_fsm.sv
module txq_head_fsm
  import txq_pkg::*;
#(
  parameter  int RING_LEN = 64,
  parameter  int AW       = 44,
  localparam int IDX_W    = $clog2(RING_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     ring_base,
  input  logic              ring_empty,
  input  logic              ctl_rst_req,
  input  logic              ctl_stall_clr,
  input  logic              ctl_stop_req,
  input  logic              stat_rd,
  input  logic              mem_rsp_valid,
  input  logic              d_sof,
  input  logic              d_mark,
  input  logic [XLEN_W-1:0] d_len,
  input  logic [BUFA_W-1:0] d_addr,
  input  logic              d_bad,
  input  logic              xfer_ready,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  output logic              xfer_valid,
  output logic              xfer_sof,
  output logic [XLEN_W-1:0] xfer_len,
  output logic [BUFA_W-1:0] xfer_addr,
  output logic [IDX_W-1:0]  head_idx,
  output logic              head_wrap,
  output logic              mk_flag,
  output logic              desc_err,
  output logic              rst_busy,
  output logic              rst_state,
  output logic              sng_state,
  output logic              err_clr
);
  localparam int               PAD_W    = AW - IDX_W - 3;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_LEN - 1);

  txq_state_e        state_q;
  logic [IDX_W-1:0]  head_q, head_nxt;
  logic              hwrap_q, hwrap_nxt;
  logic              mem_req_q;
  logic [AW-1:0]     mem_addr_q;
  logic              xv_q, xsof_q, xmark_q;
  logic [XLEN_W-1:0] xlen_q;
  logic [BUFA_W-1:0] xaddr_q;
  logic              mk_q, derr_q;
  logic              rst_pend_q, stop_pend_q;

  // R6: step by one, wrap at the ring end and flip the lap flag
  always_comb begin
    if (head_q == LAST_IDX) begin
      head_nxt  = '0;
      hwrap_nxt = ~hwrap_q;
    end else begin
      head_nxt  = head_q + IDX_W'(1);
      hwrap_nxt = hwrap_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_STALL;
      head_q      <= '0;
      hwrap_q     <= 1'b0;
      mem_req_q   <= 1'b0;
      mem_addr_q  <= '0;
      xv_q        <= 1'b0;
      xsof_q      <= 1'b0;
      xmark_q     <= 1'b0;
      xlen_q      <= '0;
      xaddr_q     <= '0;
      mk_q        <= 1'b0;
      derr_q      <= 1'b0;
      rst_pend_q  <= 1'b0;
      stop_pend_q <= 1'b0;
    end else begin
      mem_req_q <= 1'b0;
      if (ctl_rst_req)  rst_pend_q  <= 1'b1;
      if (ctl_stop_req) stop_pend_q <= 1'b1;
      if (stat_rd)      mk_q        <= 1'b0;
      unique case (state_q)
        ST_STALL: begin
          if (rst_pend_q)         state_q <= ST_RESET;
          else if (ctl_stall_clr) state_q <= ST_IDLE;
        end
        ST_IDLE: begin
          if (rst_pend_q) begin
            state_q <= ST_RESET;
          end else if (stop_pend_q) begin
            stop_pend_q <= 1'b0;
            state_q     <= ST_STOPPED;
          end else if (!ring_empty) begin
            mem_req_q  <= 1'b1;
            mem_addr_q <= ring_base + {{PAD_W{1'b0}}, head_q, 3'b000};
            state_q    <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_rsp_valid) begin
            if (d_bad) begin
              derr_q  <= 1'b1;
              head_q  <= head_nxt;
              hwrap_q <= hwrap_nxt;
              state_q <= ST_IDLE;
            end else begin
              xv_q    <= 1'b1;
              xsof_q  <= d_sof;
              xmark_q <= d_mark;
              xlen_q  <= d_len;
              xaddr_q <= d_addr;
              state_q <= ST_OFFER;
            end
          end
        end
        ST_OFFER: begin
          if (xfer_ready) begin
            xv_q    <= 1'b0;
            head_q  <= head_nxt;
            hwrap_q <= hwrap_nxt;
            if (xmark_q) mk_q <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_STOPPED: begin
          if (rst_pend_q) state_q <= ST_RESET;
        end
        ST_RESET: begin
          head_q      <= '0;
          hwrap_q     <= 1'b0;
          derr_q      <= 1'b0;
          rst_pend_q  <= 1'b0;
          stop_pend_q <= 1'b0;
          state_q     <= ST_STALL;
        end
        default: state_q <= ST_STALL;
      endcase
    end
  end

  assign mem_req    = mem_req_q;
  assign mem_addr   = mem_addr_q;
  assign xfer_valid = xv_q;
  assign xfer_sof   = xsof_q;
  assign xfer_len   = xlen_q;
  assign xfer_addr  = xaddr_q;
  assign head_idx   = head_q;
  assign head_wrap  = hwrap_q;
  assign mk_flag    = mk_q;
  assign desc_err   = derr_q;
  assign rst_busy   = rst_pend_q || (state_q == ST_RESET);
  assign rst_state  = (state_q == ST_STALL);
  assign sng_state  = (state_q == ST_STOPPED);
  assign err_clr    = (state_q == ST_RESET);

  a_r4_single_fetch: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  a_r4_no_fetch_during_offer: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !xfer_valid);

  a_r3_fetch_needs_work: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> $past(!ring_empty));

  a_r5_offer_hold: assert property (@(posedge clk) disable iff (rst)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr) &&
                                  $stable(xfer_len) && $stable(head_idx));

  a_r6_head_moves: assert property (@(posedge clk) disable iff (rst)
    xfer_valid && xfer_ready |=> head_idx != $past(head_idx));

  a_r2_stall_quiet: assert property (@(posedge clk) disable iff (rst)
    rst_state |-> !mem_req && !xfer_valid);

  a_r10_stopped_quiet: assert property (@(posedge clk) disable iff (rst)
    sng_state |=> !mem_req);
endmodule

// File: rtl/txq_ring_ctrl.sv
module txq_ring_ctrl
  import txq_pkg::*;
#(
  parameter  int RING_LEN = 64,
  parameter  int AW       = 44,
  localparam int IDX_W    = $clog2(RING_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     ring_base,
  input  logic              kick_wr,
  input  logic [IDX_W-1:0]  kick_idx,
  input  logic              kick_wrap,
  input  logic              ctl_rst_req,
  input  logic              ctl_stall_clr,
  input  logic              ctl_stop_req,
  input  logic              stat_rd,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [DESC_W-1:0] mem_rsp_data,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic              xfer_sof,
  output logic [XLEN_W-1:0] xfer_len,
  output logic [BUFA_W-1:0] xfer_addr,
  output logic [IDX_W-1:0]  head_idx,
  output logic              head_wrap,
  output logic              mk_flag,
  output logic              desc_err,
  output logic              ovf_err,
  output logic              rst_busy,
  output logic              rst_state,
  output logic              sng_state
);
  logic              d_sof, d_mark, d_bad;
  logic [XLEN_W-1:0] d_len;
  logic [BUFA_W-1:0] d_addr;
  logic              ring_empty;
  logic              err_clr;

  txq_desc_check u_dec (
    .word (mem_rsp_data),
    .sof  (d_sof),
    .mark (d_mark),
    .xlen (d_len),
    .bufa (d_addr),
    .bad  (d_bad)
  );

  txq_kick_track #(.RING_LEN(RING_LEN)) u_kick (
    .clk        (clk),
    .rst        (rst),
    .kick_wr    (kick_wr),
    .kick_idx   (kick_idx),
    .kick_wrap  (kick_wrap),
    .head_idx   (head_idx),
    .head_wrap  (head_wrap),
    .ovf_clr    (err_clr),
    .ring_empty (ring_empty),
    .ovf_err    (ovf_err)
  );

  txq_head_fsm #(.RING_LEN(RING_LEN), .AW(AW)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .ring_base     (ring_base),
    .ring_empty    (ring_empty),
    .ctl_rst_req   (ctl_rst_req),
    .ctl_stall_clr (ctl_stall_clr),
    .ctl_stop_req  (ctl_stop_req),
    .stat_rd       (stat_rd),
    .mem_rsp_valid (mem_rsp_valid),
    .d_sof         (d_sof),
    .d_mark        (d_mark),
    .d_len         (d_len),
    .d_addr        (d_addr),
    .d_bad         (d_bad),
    .xfer_ready    (xfer_ready),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .xfer_valid    (xfer_valid),
    .xfer_sof      (xfer_sof),
    .xfer_len      (xfer_len),
    .xfer_addr     (xfer_addr),
    .head_idx      (head_idx),
    .head_wrap     (head_wrap),
    .mk_flag       (mk_flag),
    .desc_err      (desc_err),
    .rst_busy      (rst_busy),
    .rst_state     (rst_state),
    .sng_state     (sng_state),
    .err_clr       (err_clr)
  );
endmodule

// File: tb/tb_txq_ring_ctrl.sv
module tb_txq_ring_ctrl;
  localparam int RING_LEN = 64;
  localparam int AW       = 44;
  localparam int IDX_W    = 6;
  localparam logic [AW-1:0] BASE = 44'h000_0040_0000;

  typedef struct packed {
    logic        sof;
    logic        mark;
    logic [3:0]  cnt;
    logic [12:0] len;
    logic [43:0] addr;
  } vec_t;

  // descriptor table: good, good, zero length, marked max, count 2, count 0, marked, good
  localparam vec_t VEC [8] = '{
    '{1'b1, 1'b0, 4'd1, 13'd60,   44'h000_0000_1000},
    '{1'b0, 1'b0, 4'd1, 13'd1,    44'h000_0000_2040},
    '{1'b1, 1'b0, 4'd1, 13'd0,    44'h000_0000_5000},
    '{1'b1, 1'b1, 4'd1, 13'd8191, 44'hFFF_FFFF_FFFF},
    '{1'b1, 1'b0, 4'd2, 13'd100,  44'h000_0000_6000},
    '{1'b1, 1'b0, 4'd0, 13'd100,  44'h000_0000_7000},
    '{1'b0, 1'b1, 4'd1, 13'd1500, 44'h000_0000_3000},
    '{1'b1, 1'b0, 4'd1, 13'd64,   44'h123_4567_89AB}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic kick_wr = 1'b0, kick_wrap = 1'b0;
  logic [IDX_W-1:0] kick_idx = '0;
  logic ctl_rst_req = 1'b0, ctl_stall_clr = 1'b0, ctl_stop_req = 1'b0, stat_rd = 1'b0;
  logic mem_req, mem_rsp_valid = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_rsp_data = '0;
  logic xfer_valid, xfer_ready = 1'b0, xfer_sof;
  logic [12:0] xfer_len;
  logic [43:0] xfer_addr;
  logic [IDX_W-1:0] head_idx;
  logic head_wrap, mk_flag, desc_err, ovf_err, rst_busy, rst_state, sng_state;

  always #5 clk = ~clk;

  txq_ring_ctrl #(.RING_LEN(RING_LEN), .AW(AW)) dut (
    .clk(clk), .rst(rst), .ring_base(BASE),
    .kick_wr(kick_wr), .kick_idx(kick_idx), .kick_wrap(kick_wrap),
    .ctl_rst_req(ctl_rst_req), .ctl_stall_clr(ctl_stall_clr),
    .ctl_stop_req(ctl_stop_req), .stat_rd(stat_rd),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_sof(xfer_sof),
    .xfer_len(xfer_len), .xfer_addr(xfer_addr),
    .head_idx(head_idx), .head_wrap(head_wrap), .mk_flag(mk_flag),
    .desc_err(desc_err), .ovf_err(ovf_err), .rst_busy(rst_busy),
    .rst_state(rst_state), .sng_state(sng_state)
  );

  int n_chk = 0, n_fail = 0;
  int ready_mode = 0;  // 0 never, 1 always, 2 alternate
  logic [63:0] dmem [64];
  logic        acc_sof  [512];
  logic [12:0] acc_len  [512];
  logic [43:0] acc_addr [512];
  logic [43:0] mem_a    [512];
  int acc_n = 0, mem_n = 0;

  function automatic logic [63:0] mk_desc(logic s, logic m, logic [3:0] c,
                                          logic [12:0] l, logic [43:0] a);
    return {s, m, c, 1'b0, l, a};
  endfunction

  task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kick(input logic [IDX_W-1:0] idx, input logic w);
    @(negedge clk);
    kick_wr = 1'b1; kick_idx = idx; kick_wrap = w;
    @(negedge clk);
    kick_wr = 1'b0;
  endtask

  task automatic pulse_rst_req();
    @(negedge clk); ctl_rst_req = 1'b1; @(negedge clk); ctl_rst_req = 1'b0;
  endtask
  task automatic pulse_stall_clr();
    @(negedge clk); ctl_stall_clr = 1'b1; @(negedge clk); ctl_stall_clr = 1'b0;
  endtask
  task automatic pulse_stop();
    @(negedge clk); ctl_stop_req = 1'b1; @(negedge clk); ctl_stop_req = 1'b0;
  endtask
  task automatic pulse_stat_rd();
    @(negedge clk); stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
  endtask

  // downstream reader and descriptor memory model, active on falling edges
  initial begin
    forever begin
      @(negedge clk);
      case (ready_mode)
        0: xfer_ready = 1'b0;
        1: xfer_ready = 1'b1;
        default: xfer_ready = ~xfer_ready;
      endcase
      if (xfer_valid && xfer_ready && acc_n < 512) begin
        acc_sof[acc_n]  = xfer_sof;
        acc_len[acc_n]  = xfer_len;
        acc_addr[acc_n] = xfer_addr;
        acc_n++;
      end
      if (mem_req) begin
        if (mem_n < 512) begin
          mem_a[mem_n] = mem_addr;
          mem_n++;
        end
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = dmem[6'((mem_addr - BASE) >> 3)];
      end else begin
        mem_rsp_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int k, a0, m0;
    for (int i = 0; i < 64; i++) dmem[i] = '0;
    for (int i = 0; i < 8; i++)
      dmem[i] = mk_desc(VEC[i].sof, VEC[i].mark, VEC[i].cnt, VEC[i].len, VEC[i].addr);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk_eq("R1 head_idx", head_idx, 0);
    chk_eq("R1 head_wrap", head_wrap, 0);
    chk_eq("R1 rst_state", rst_state, 1);
    chk_eq("R1 flags", {sng_state, mk_flag, desc_err, ovf_err}, 0);
    chk_eq("R1 outputs idle", {mem_req, xfer_valid}, 0);

    // R2 stalled engine ignores posted work
    ready_mode = 2;
    kick(6'd8, 1'b0);
    cycles(10);
    chk_eq("R2 no fetch while stalled", mem_n, 0);
    chk_eq("R2 still stalled", rst_state, 1);
    pulse_stall_clr();
    cycles(100);
    chk_eq("R2 released", rst_state, 0);

    // table walk: R4 addresses, R5 fields, R7 skips
    k = 0;
    chk_eq("R4 fetch count", mem_n, 8);
    for (int i = 0; i < 8; i++) begin
      chk_eq("R4 fetch address", mem_a[i], BASE + 44'(i * 8));
      if (VEC[i].cnt == 4'd1 && VEC[i].len != 13'd0) begin
        chk_eq("R5 sof", acc_sof[k], VEC[i].sof);
        chk_eq("R5 len", acc_len[k], VEC[i].len);
        chk_eq("R5 addr", acc_addr[k], VEC[i].addr);
        k++;
      end
    end
    chk_eq("R7 bad descriptors skipped", acc_n, k);
    chk_eq("R7 desc_err set", desc_err, 1);
    chk_eq("R6 head after walk", head_idx, 8);
    chk_eq("R9 mk_flag set", mk_flag, 1);
    pulse_stat_rd();
    cycles(1);
    chk_eq("R9 mk_flag cleared by read", mk_flag, 0);

    // R6 wrap: 60 entries from 8 around to 4
    for (int i = 0; i < 64; i++)
      dmem[i] = mk_desc(1'b1, 1'b0, 4'd1, 13'(i + 1), 44'(i * 256));
    ready_mode = 1;
    a0 = acc_n; m0 = mem_n;
    kick(6'd4, 1'b1);
    cycles(300);
    chk_eq("R6 count across wrap", acc_n - a0, 60);
    chk_eq("R6 first after kick", acc_len[a0], 9);
    chk_eq("R6 last before wrap", acc_len[a0 + 55], 64);
    chk_eq("R6 first after wrap", acc_len[a0 + 56], 1);
    chk_eq("R6 wrapped address", mem_a[m0 + 56], BASE);
    chk_eq("R6 head index", head_idx, 4);
    chk_eq("R6 head_wrap toggled", head_wrap, 1);

    // R3 full ring: equal index, differing lap flags
    a0 = acc_n;
    kick(6'd4, 1'b0);
    cycles(300);
    chk_eq("R3 full ring processed", acc_n - a0, 64);
    chk_eq("R3 first entry", acc_len[a0], 5);
    chk_eq("R3 last entry", acc_len[a0 + 63], 4);
    chk_eq("R3 head_wrap", head_wrap, 0);

    // R8 overflow rejected
    m0 = mem_n;
    kick(6'd5, 1'b1);
    cycles(10);
    chk_eq("R8 ovf_err set", ovf_err, 1);
    chk_eq("R8 tail unchanged, no fetch", mem_n - m0, 0);
    chk_eq("R8 head unchanged", head_idx, 4);

    // R10 stop completes current descriptor
    ready_mode = 0;
    a0 = acc_n; m0 = mem_n;
    kick(6'd10, 1'b0);
    for (int i = 0; i < 50 && !xfer_valid; i++) @(negedge clk);
    pulse_stop();
    cycles(4);
    chk_eq("R5 request held", xfer_valid, 1);
    chk_eq("R10 not stopped while busy", sng_state, 0);
    chk_eq("R5 head held", head_idx, 4);
    ready_mode = 1;
    cycles(6);
    chk_eq("R10 stopped", sng_state, 1);
    chk_eq("R10 head after stop", head_idx, 5);
    cycles(10);
    chk_eq("R10 single fetch", mem_n - m0, 1);
    chk_eq("R10 single transfer", acc_n - a0, 1);

    // R11 control reset keeps tail
    @(negedge clk);
    ctl_rst_req = 1'b1;
    @(negedge clk);
    ctl_rst_req = 1'b0;
    chk_eq("R11 rst_busy", rst_busy, 1);
    cycles(5);
    chk_eq("R11 done", rst_busy, 0);
    chk_eq("R11 parked", rst_state, 1);
    chk_eq("R11 head zero", {head_wrap, head_idx}, 0);
    chk_eq("R11 errors cleared", {ovf_err, desc_err, sng_state}, 0);
    a0 = acc_n; m0 = mem_n;
    pulse_stall_clr();
    cycles(60);
    chk_eq("R11 follows old tail", acc_n - a0, 10);
    chk_eq("R11 restart address", mem_a[m0], BASE);
    chk_eq("R11 last entry", acc_len[a0 + 9], 10);
    chk_eq("R11 head at tail", head_idx, 10);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule